// File: doc/BRIEF.md
# Bidirectional Peripheral Port Pair with Edge-Captured Input

This block gives a small processor two 8-bit general-purpose ports, called A and B. Each port has a direction register, an output register and a capture register. The processor writes and reads them through a 2-bit register select, write and read strobes, and 8-bit write and read data paths.

Each pin is either an output, driven from its output-register bit, or an input with its driver off. When a port is read, each input bit returns one of two values. With capture disabled it returns the live pin level. With capture enabled it returns the snapshot taken at the last active edge of that port's control line. The control line is synchronized by two flip-flops. The edge that counts as active, rising or falling, is chosen by a configuration input.

The reset input is asynchronous and active low. Its release is synchronized inside the block.

Top module: `dport_top`

## Requirements
- R1: While reset is held, and after it is released, every direction bit is 0, so `*_pin_oe` is 0x00. Every output-register bit is 0, so `*_pin_out` is 0x00. Every capture register is 0, so a read of a port's data register with capture enabled returns 0x00 even when the pins read 0xFF.
- R2: Register select decodes as follows: 0 is port B data, 1 is port A data, 2 is port B direction, 3 is port A direction. A write changes only the addressed register, and a read of a direction register returns the value last written to it.
- R3: `*_pin_oe[i]` equals direction bit i. `*_pin_out[i]` equals output-register bit i when direction bit i is 1, and is 0 when direction bit i is 0.
- R4: A write to an output register while some pins are inputs does not change `*_pin_out` or `*_pin_oe` for those pins. The stored value appears on `*_pin_out` in the cycle after a later write sets the direction bits to 1.
- R5: `bus_rdata` is registered. It takes the addressed value at the rising edge where `bus_rd` is 1, and it holds its value at every edge where `bus_rd` is 0.
- R6: When port data is read, each output bit (direction 1) returns the output-register bit, not the pin level.
- R7: With capture disabled (`*_latch_en`=0), each input bit of a data read returns the pin level at the read edge.
- R8: With capture enabled, each input bit of a data read returns the pin level captured, for all 8 bits together, at the third rising clock edge after the control line changes. Later pin changes do not affect the read until the next active edge.
- R9: `*_edge_rise`=1 makes a 0-to-1 control transition active, and `*_edge_rise`=0 makes a 1-to-0 transition active. A transition in the other direction captures nothing.
- R10: The two ports are independent. An active edge on one port's control line leaves the other port's capture register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 2 | Register select |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| a_pin_in | input | 8 | Port A pin levels |
| a_pin_out | output | 8 | Port A drive values |
| a_pin_oe | output | 8 | Port A per-bit output enables |
| a_ctl | input | 1 | Port A capture control line (asynchronous) |
| a_latch_en | input | 1 | Port A capture enable for reads |
| a_edge_rise | input | 1 | Port A active-edge select (1 = rising) |
| b_pin_in | input | 8 | Port B pin levels |
| b_pin_out | output | 8 | Port B drive values |
| b_pin_oe | output | 8 | Port B per-bit output enables |
| b_ctl | input | 1 | Port B capture control line (asynchronous) |
| b_latch_en | input | 1 | Port B capture enable for reads |
| b_edge_rise | input | 1 | Port B active-edge select (1 = rising) |

## Verification
Every output-register value from 0 to 255 is written under five direction masks on each port. In each case the pins are held at the complement of the written value. This makes every read bit show whether it came from the register or from the pin. Capture is tried with both edge polarities. Each time, the pin value is changed after the capture edge, so a stale snapshot can be told apart from a live level. Wrong-direction transitions and edges on the other port are then applied to show that they capture nothing.

// File: rtl/dport_pkg.sv
package dport_pkg;
  localparam int unsigned PORT_W  = 8;
  localparam int unsigned N_PORTS = 2;
  localparam int unsigned SYNC_STAGES = 2;

  typedef enum logic [1:0] {
    SEL_DATA_B = 2'd0,
    SEL_DATA_A = 2'd1,
    SEL_DIR_B  = 2'd2,
    SEL_DIR_A  = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/dport_rst_sync.sv
module dport_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_q = chain_q[STAGES-1];
endmodule

// File: rtl/dport_edge_sync.sv
module dport_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  input  logic rise_sel,
  output logic edge_hit
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;
  logic              prev_q;
  logic              cur;

  assign cur = sync_q[STAGES-1];

  generate
    if (STAGES == 1) begin : g_one
      always_comb sync_d = async_in;
    end else begin : g_many
      always_comb sync_d = {sync_q[STAGES-2:0], async_in};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      prev_q <= cur;
    end
  end

  always_comb begin
    if (rise_sel) edge_hit = cur & ~prev_q;
    else          edge_hit = ~cur & prev_q;
  end
endmodule

// File: rtl/dport_lane.sv
module dport_lane #(
  parameter int unsigned W = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_data_en,
  input  logic         wr_dir_en,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] pin_in,
  input  logic         ctl,
  input  logic         latch_en,
  input  logic         edge_rise,
  output logic [W-1:0] pin_out,
  output logic [W-1:0] pin_oe,
  output logic [W-1:0] data_view,
  output logic [W-1:0] dir_view
);
  logic [W-1:0] dir_q, dir_d;
  logic [W-1:0] outr_q, outr_d;
  logic [W-1:0] snap_q, snap_d;
  logic         cap_hit;

  dport_edge_sync #(.STAGES(SYNC_STAGES)) u_edge (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (ctl),
    .rise_sel (edge_rise),
    .edge_hit (cap_hit)
  );

  always_comb begin
    dir_d  = wr_dir_en  ? wdata  : dir_q;
    outr_d = wr_data_en ? wdata  : outr_q;
    snap_d = cap_hit    ? pin_in : snap_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q  <= '0;
      outr_q <= '0;
      snap_q <= '0;
    end else begin
      dir_q  <= dir_d;
      outr_q <= outr_d;
      snap_q <= snap_d;
    end
  end

  always_comb begin
    for (int i = 0; i < W; i++) begin
      pin_oe[i]  = dir_q[i];
      pin_out[i] = dir_q[i] & outr_q[i];
      if (dir_q[i])      data_view[i] = outr_q[i];
      else if (latch_en) data_view[i] = snap_q[i];
      else               data_view[i] = pin_in[i];
    end
  end

  assign dir_view = dir_q;
endmodule

// File: rtl/dport_top.sv
module dport_top
  import dport_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [PORT_W-1:0] bus_wdata,
  output logic [PORT_W-1:0] bus_rdata,
  input  logic [PORT_W-1:0] a_pin_in,
  output logic [PORT_W-1:0] a_pin_out,
  output logic [PORT_W-1:0] a_pin_oe,
  input  logic              a_ctl,
  input  logic              a_latch_en,
  input  logic              a_edge_rise,
  input  logic [PORT_W-1:0] b_pin_in,
  output logic [PORT_W-1:0] b_pin_out,
  output logic [PORT_W-1:0] b_pin_oe,
  input  logic              b_ctl,
  input  logic              b_latch_en,
  input  logic              b_edge_rise
);
  logic rst_q;

  dport_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk   (clk),
    .rst_n (rst_n),
    .rst_q (rst_q)
  );

  // index 0 = port B, index 1 = port A (matches bus_addr[0])
  logic [N_PORTS-1:0][PORT_W-1:0] pin_in_v, pin_out_v, pin_oe_v, data_v, dir_v;
  logic [N_PORTS-1:0]             ctl_v, len_v, rise_v;

  assign pin_in_v = {a_pin_in, b_pin_in};
  assign ctl_v    = {a_ctl, b_ctl};
  assign len_v    = {a_latch_en, b_latch_en};
  assign rise_v   = {a_edge_rise, b_edge_rise};

  generate
    for (genvar p = 0; p < N_PORTS; p++) begin : g_port
      logic sel_me;
      assign sel_me = (bus_addr[0] == p[0]);
      dport_lane #(.W(PORT_W), .SYNC_STAGES(SYNC_STAGES)) u_lane (
        .clk        (clk),
        .rst_n      (rst_q),
        .wr_data_en (bus_wr & sel_me & ~bus_addr[1]),
        .wr_dir_en  (bus_wr & sel_me &  bus_addr[1]),
        .wdata      (bus_wdata),
        .pin_in     (pin_in_v[p]),
        .ctl        (ctl_v[p]),
        .latch_en   (len_v[p]),
        .edge_rise  (rise_v[p]),
        .pin_out    (pin_out_v[p]),
        .pin_oe     (pin_oe_v[p]),
        .data_view  (data_v[p]),
        .dir_view   (dir_v[p])
      );
    end
  endgenerate

  assign a_pin_out = pin_out_v[1];
  assign a_pin_oe  = pin_oe_v[1];
  assign b_pin_out = pin_out_v[0];
  assign b_pin_oe  = pin_oe_v[0];

  logic [PORT_W-1:0] rdata_d, rdata_q;

  always_comb begin
    unique case (reg_sel_e'(bus_addr))
      SEL_DATA_B: rdata_d = data_v[0];
      SEL_DATA_A: rdata_d = data_v[1];
      SEL_DIR_B:  rdata_d = dir_v[0];
      SEL_DIR_A:  rdata_d = dir_v[1];
      default:    rdata_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q)      rdata_q <= '0;
    else if (bus_rd) rdata_q <= rdata_d;
  end

  assign bus_rdata = rdata_q;
endmodule

// File: rtl/dport_chk.sv
module dport_chk (
  input logic       clk,
  input logic       rst_q,
  input logic [1:0] bus_addr,
  input logic       bus_wr,
  input logic       bus_rd,
  input logic [7:0] bus_rdata,
  input logic [7:0] a_pin_out,
  input logic [7:0] a_pin_oe,
  input logic [7:0] b_pin_out,
  input logic [7:0] b_pin_oe
);
  // R1
  reset_clear_chk: assert property (@(posedge clk)
    !rst_q |=> (a_pin_oe == 8'h00 && b_pin_oe == 8'h00 && a_pin_out == 8'h00 && b_pin_out == 8'h00));

  // R2
  a_dir_write_only_chk: assert property (@(posedge clk) disable iff (!rst_q)
    !$stable(a_pin_oe) |-> $past(bus_wr && bus_addr == 2'd3));

  // R2
  b_dir_write_only_chk: assert property (@(posedge clk) disable iff (!rst_q)
    !$stable(b_pin_oe) |-> $past(bus_wr && bus_addr == 2'd2));

  // R4
  a_drive_hold_chk: assert property (@(posedge clk) disable iff (!rst_q)
    !$stable(a_pin_out) |-> $past(bus_wr && bus_addr[0]));

  // R4
  b_drive_hold_chk: assert property (@(posedge clk) disable iff (!rst_q)
    !$stable(b_pin_out) |-> $past(bus_wr && !bus_addr[0]));

  // R5
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_q)
    !$past(bus_rd) |-> $stable(bus_rdata));
endmodule

bind dport_top dport_chk u_chk (
  .clk       (clk),
  .rst_q     (rst_q),
  .bus_addr  (bus_addr),
  .bus_wr    (bus_wr),
  .bus_rd    (bus_rd),
  .bus_rdata (bus_rdata),
  .a_pin_out (a_pin_out),
  .a_pin_oe  (a_pin_oe),
  .b_pin_out (b_pin_out),
  .b_pin_oe  (b_pin_oe)
);

// File: tb/sim_dport_top.sv
`timescale 1ns/1ps
module sim_dport_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic [7:0] a_pin_in = 8'h00, b_pin_in = 8'h00;
  logic [7:0] a_pin_out, a_pin_oe, b_pin_out, b_pin_oe;
  logic       a_ctl = 1'b0, b_ctl = 1'b0;
  logic       a_latch_en = 1'b0, b_latch_en = 1'b0;
  logic       a_edge_rise = 1'b1, b_edge_rise = 1'b1;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  dport_top u0 (.*);

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // p: 1 = port A, 0 = port B
  task automatic set_pins(input bit p, input logic [7:0] v);
    if (p) a_pin_in = v; else b_pin_in = v;
  endtask

  initial begin
    logic [7:0] r;
    logic [7:0] masks [5] = '{8'h00, 8'hFF, 8'h0F, 8'hA5, 8'h3C};

    // R1: reset state
    a_pin_in = 8'hFF; b_pin_in = 8'hFF; a_latch_en = 1'b1; b_latch_en = 1'b1;
    idle(2);
    check("R1 oe A in reset", a_pin_oe, 8'h00);
    check("R1 out B in reset", b_pin_out, 8'h00);
    rst_n = 1'b1;
    idle(4);
    check("R1 oe A", a_pin_oe, 8'h00);
    check("R1 oe B", b_pin_oe, 8'h00);
    check("R1 out A", a_pin_out, 8'h00);
    rd(2'd3, r); check("R1 dir A read", r, 8'h00);
    rd(2'd2, r); check("R1 dir B read", r, 8'h00);
    rd(2'd1, r); check("R1 snapshot A cleared", r, 8'h00);
    rd(2'd0, r); check("R1 snapshot B cleared", r, 8'h00);
    a_latch_en = 1'b0; b_latch_en = 1'b0;

    // R4: write while input, then turn to output
    wr(2'd1, 8'h5A);
    idle(3);
    check("R4 A out unchanged while input", a_pin_out, 8'h00);
    check("R4 A oe unchanged", a_pin_oe, 8'h00);
    wr(2'd3, 8'hFF);
    check("R4 A stored value appears", a_pin_out, 8'h5A);
    check("R2 B untouched by A writes", b_pin_oe, 8'h00);
    wr(2'd3, 8'h00);

    // R3 R6 R7 R2: sweep every value under several masks on both ports
    for (int p = 0; p < 2; p++) begin
      for (int m = 0; m < 5; m++) begin
        logic [7:0] mk;
        mk = masks[m];
        wr(p ? 2'd3 : 2'd2, mk);
        rd(p ? 2'd3 : 2'd2, r); check("R2 dir readback", r, mk);
        for (int v = 0; v < 256; v++) begin
          logic [7:0] vv;
          vv = v[7:0];
          set_pins(p[0], ~vv);
          wr(p ? 2'd1 : 2'd0, vv);
          check("R3 oe", p ? a_pin_oe : b_pin_oe, mk);
          check("R3 drive", p ? a_pin_out : b_pin_out, vv & mk);
          rd(p ? 2'd1 : 2'd0, r);
          check("R6 R7 data read", r, (vv & mk) | (~vv & ~mk));
        end
      end
      wr(p ? 2'd3 : 2'd2, 8'h00);
    end

    // R5: rdata holds without read strobe
    rd(2'd0, r);
    b_pin_in = 8'hC3;
    idle(3);
    check("R5 rdata hold", bus_rdata, r);

    // R8 R9: rising capture on A
    a_latch_en = 1'b1; a_edge_rise = 1'b1; a_ctl = 1'b0;
    idle(5);
    a_pin_in = 8'h96;
    @(negedge clk); a_ctl = 1'b1;
    idle(5);
    a_pin_in = 8'h21;
    rd(2'd1, r); check("R8 rising capture A", r, 8'h96);
    a_latch_en = 1'b0;
    rd(2'd1, r); check("R7 live when disabled", r, 8'h21);
    a_latch_en = 1'b1;
    // R9: falling transition ignored with rising select
    a_pin_in = 8'h44;
    @(negedge clk); a_ctl = 1'b0;
    idle(5);
    rd(2'd1, r); check("R9 wrong edge ignored", r, 8'h96);
    // R9: falling select
    a_edge_rise = 1'b0;
    idle(3);
    a_pin_in = 8'h7E;
    @(negedge clk); a_ctl = 1'b1;
    idle(5);
    rd(2'd1, r); check("R9 rise ignored with falling select", r, 8'h96);
    @(negedge clk); a_ctl = 1'b0;
    idle(5);
    a_pin_in = 8'h00;
    rd(2'd1, r); check("R9 falling capture", r, 8'h7E);
    // R8: output bits still from output register with capture on
    wr(2'd1, 8'hF0); wr(2'd3, 8'hF0);
    rd(2'd1, r); check("R8 mixed with outputs", r, 8'hFE);
    wr(2'd3, 8'h00);

    // R10: edge on A does not capture B
    b_latch_en = 1'b1; b_edge_rise = 1'b1; b_ctl = 1'b0;
    b_pin_in = 8'hAA;
    @(negedge clk); b_ctl = 1'b1;
    idle(5);
    b_pin_in = 8'h55; a_edge_rise = 1'b1;
    idle(2);
    @(negedge clk); a_ctl = 1'b1;
    idle(5);
    rd(2'd0, r); check("R10 B unaffected by A edge", r, 8'hAA);
    rd(2'd1, r); check("R10 A captured own edge", r, 8'h00);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule